// File: doc/BRIEF.md
# Latching Tone Switch Controller

This block sits behind a tone detector. It turns two raw flags into the final registered state of an output switch. The flags are tone present and signal lost. A set of plain mode pins shapes the result. The switch can simply follow the tone. It can also latch, in one of two directions: a recognised tone either drives it on and keeps it on, or drives it off and keeps it off. A direct clear returns the switch to its idle level. The idle level is off, except in latch-to-off operation, where it is on (armed).

When the detector reports that the input signal has disappeared, a loss policy chosen every clock decides the outcome. The policy can force the switch off at once. It can force the switch off only after the loss has lasted a programmable number of cycles. Or it can freeze the switch where it is. While the signal is lost, the tone flag is disregarded.

The block has no data stream, so there is no valid/ready handshake and no back-pressure. Every pin is a level-sensitive control or status pin, sampled on each rising clock edge. The output changes on the same edge that samples the inputs causing the change.

Top module: `tone_switch_ctrl`

## Requirements
- R1: While `rst_n` is low, `sw_o` is 0. After release the block runs unlatched until the first clear, so `sw_o` follows `tone_i`.
- R2: In unlatched operation with `los_i`=0, `sw_o` after each edge equals the `tone_i` sampled at that edge.
- R3: In latch-to-on operation with `los_i`=0, an edge that samples `tone_i`=1 sets `sw_o` to 1. `sw_o` then stays 1 when `tone_i` returns to 0.
- R4: In latch-to-off operation with `los_i`=0, an edge that samples `tone_i`=1 clears `sw_o` to 0. `sw_o` then stays 0 when `tone_i` returns to 0.
- R5: `clr_i` overrides every other input except `rst_n`. An edge sampling `clr_i`=1 sets `sw_o` to the idle level, which is 1 only when `latch_en_i`=1 and `latch_dir_i`=0 at that edge, and 0 in every other case.
- R6: Latched operation (`latch_en_i`=1) and direction (`latch_dir_i`=1 means latch to on, 0 means latch to off) are captured only at edges where `clr_i`=1. Changing those pins at other times has no effect on `sw_o`.
- R7: With `loss_mode_i`=2'b00, an edge sampling `los_i`=1 forces `sw_o` to 0.
- R8: With `loss_mode_i`=2'b01 and delay D on `delay_i`, `sw_o` holds through the first D consecutive edges sampling `los_i`=1. It is forced to 0 on the (D+1)th such edge and every later one. D=0 acts at once.
- R9: An edge sampling `los_i`=0 restarts the loss count, so a loss shorter than the delay, followed by another, never forces the switch off.
- R10: With `loss_mode_i`=2'b10 or 2'b11, `sw_o` holds its value while `los_i`=1, whatever `tone_i` does.
- R11: `loss_mode_i` is sampled on every edge. Changing it in the middle of a loss takes effect at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_i | input | 1 | Direct clear, also loads the latch configuration |
| latch_en_i | input | 1 | 1 = latched operation (captured on clear) |
| latch_dir_i | input | 1 | 1 = latch to on, 0 = latch to off (captured on clear) |
| loss_mode_i | input | 2 | 00 off at once, 01 off after delay, 1x hold |
| delay_i | input | DLY_W | Loss cycles tolerated in delayed mode |
| tone_i | input | 1 | Tone-present flag from the detector |
| los_i | input | 1 | Signal-lost flag from the detector |
| sw_o | output | 1 | Registered switch state |

## Verification
The bench runs the delayed loss policy up to exactly D edges and through the (D+1)th. A counter off by one would open the switch one edge early or late. It breaks a loss into two sub-delay bursts. A count that fails to restart would then drop the switch on the second burst.

It changes the latch pins without a clear and checks that the latched switch keeps its value. A design that reads the pins live would fall back to following the tone. It also switches the loss policy from hold to immediate in the middle of a loss, and it feeds tone pulses while the signal is lost. A design that lets tone win over loss would move the switch when it should stay put.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

  typedef enum logic [1:0] {
    LP_OFF      = 2'b00,
    LP_DELAY    = 2'b01,
    LP_HOLD     = 2'b10,
    LP_HOLD_ALT = 2'b11
  } loss_pol_e;

  // Level the switch takes after a direct clear.
  function automatic logic idle_level(input logic latched, input logic dir_on);
    return latched & ~dir_on;
  endfunction

endpackage

// File: rtl/tsc_cfg_latch.sv
module tsc_cfg_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic latch_en_i,
  input  logic latch_dir_i,
  output logic latched_o,
  output logic dir_on_o
);

  logic latched_q;
  logic dir_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      latched_q <= 1'b0;
      dir_q     <= 1'b0;
    end else if (clr_i) begin
      latched_q <= latch_en_i;
      dir_q     <= latch_dir_i;
    end
  end

  assign latched_o = latched_q;
  assign dir_on_o  = dir_q;

  // R6: configuration only moves on a clear
  p_cfg_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_i |=> $stable({latched_q, dir_q}));

  p_cfg_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (latched_q == $past(latch_en_i)) && (dir_q == $past(latch_dir_i)));

endmodule

// File: rtl/tsc_loss_timer.sv
module tsc_loss_timer #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             los_i,
  input  logic [DLY_W-1:0] delay_i,
  output logic             expired_o
);

  logic [DLY_W-1:0] cnt_q;
  logic             reached;

  assign reached   = (cnt_q >= delay_i);
  assign expired_o = los_i & reached;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (!los_i)   cnt_q <= '0;
    else if (!reached) cnt_q <= cnt_q + 1'b1;
  end

  // R9: a sample without loss restarts the count
  p_cnt_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !los_i |=> cnt_q == '0);

  // R8: count advances by one per lost sample until the delay is met
  p_cnt_step_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (los_i && cnt_q < delay_i) |=> cnt_q == DLY_W'($past(cnt_q) + 1'b1));

  p_expire_needs_loss_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expired_o |-> los_i);

endmodule

// File: rtl/tone_switch_ctrl.sv
module tone_switch_ctrl #(
  parameter int DLY_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr_i,
  input  logic             latch_en_i,
  input  logic             latch_dir_i,
  input  logic [1:0]       loss_mode_i,
  input  logic [DLY_W-1:0] delay_i,
  input  logic             tone_i,
  input  logic             los_i,
  output logic             sw_o
);
  import tsc_pkg::*;

  logic      latched;
  logic      dir_on;
  logic      expired;
  logic      sw_q;
  logic      sw_d;
  loss_pol_e pol;

  assign pol = loss_pol_e'(loss_mode_i);

  tsc_cfg_latch u_cfg (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .latch_en_i (latch_en_i),
    .latch_dir_i(latch_dir_i),
    .latched_o  (latched),
    .dir_on_o   (dir_on)
  );

  tsc_loss_timer #(.DLY_W(DLY_W)) u_timer (
    .clk      (clk),
    .rst_n    (rst_n),
    .los_i    (los_i),
    .delay_i  (delay_i),
    .expired_o(expired)
  );

  // Priority: clear, then loss policy, then tone handling.
  always_comb begin
    sw_d = sw_q;
    if (clr_i) begin
      sw_d = idle_level(latch_en_i, latch_dir_i);
    end else if (los_i) begin
      unique case (pol)
        LP_OFF:   sw_d = 1'b0;
        LP_DELAY: sw_d = expired ? 1'b0 : sw_q;
        default:  sw_d = sw_q;
      endcase
    end else if (!latched) begin
      sw_d = tone_i;
    end else if (dir_on) begin
      sw_d = sw_q | tone_i;
    end else begin
      sw_d = sw_q & ~tone_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sw_q <= 1'b0;
    else        sw_q <= sw_d;
  end

  assign sw_o = sw_q;

  // R1: output is low during reset
  always_comb begin
    if (!rst_n) p_reset_low_r1: assert (sw_q == 1'b0);
  end

  p_clr_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> sw_q == idle_level($past(latch_en_i), $past(latch_dir_i)));

  p_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !los_i && !latched) |=> sw_q == $past(tone_i));

  p_latch_on_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !los_i && latched && dir_on && (sw_q || tone_i)) |=> sw_q);

  p_latch_off_keep_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !los_i && latched && !dir_on && (!sw_q || tone_i)) |=> !sw_q);

  p_failsafe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && los_i && loss_mode_i == 2'b00) |=> !sw_q);

  p_delay_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && los_i && loss_mode_i == 2'b01 && !expired) |=> $stable(sw_q));

  p_delay_off_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && los_i && loss_mode_i == 2'b01 && expired) |=> !sw_q);

  p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && los_i && loss_mode_i[1]) |=> $stable(sw_q));

endmodule

// File: tb/tone_switch_ctrl_tb_top.sv
module tone_switch_ctrl_tb_top;

  localparam int DLY_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             clr_i = 1'b0;
  logic             latch_en_i = 1'b0;
  logic             latch_dir_i = 1'b0;
  logic [1:0]       loss_mode_i = 2'b00;
  logic [DLY_W-1:0] delay_i = '0;
  logic             tone_i = 1'b0;
  logic             los_i = 1'b0;
  logic             sw_o;

  int checks = 0;
  int fails  = 0;

  // bench model state
  logic             m_lat = 1'b0;
  logic             m_dir = 1'b0;
  logic             m_sw  = 1'b0;
  logic [DLY_W-1:0] m_cnt = '0;

  always #10 clk = ~clk;

  tone_switch_ctrl #(.DLY_W(DLY_W)) dut_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr_i      (clr_i),
    .latch_en_i (latch_en_i),
    .latch_dir_i(latch_dir_i),
    .loss_mode_i(loss_mode_i),
    .delay_i    (delay_i),
    .tone_i     (tone_i),
    .los_i      (los_i),
    .sw_o       (sw_o)
  );

  function automatic string auto_tag(input logic c, input logic l, input logic [1:0] lm);
    if (c)         return "R5";
    if (l) begin
      if (lm == 2'b00) return "R7";
      if (lm == 2'b01) return "R8";
      return "R10";
    end
    if (!m_lat)    return "R2";
    return m_dir ? "R3" : "R4";
  endfunction

  // expected next state from the requirements
  function automatic logic next_sw(input logic c, input logic le, input logic ld,
                                   input logic [1:0] lm, input logic [DLY_W-1:0] d,
                                   input logic t, input logic l);
    if (c) return le & ~ld;
    if (l) begin
      if (lm == 2'b00) return 1'b0;
      if (lm == 2'b01) return (m_cnt >= d) ? 1'b0 : m_sw;
      return m_sw;
    end
    if (!m_lat) return t;
    if (m_dir)  return m_sw | t;
    return m_sw & ~t;
  endfunction

  task automatic check(input string tag, input logic exp_v);
    checks++;
    if (sw_o !== exp_v) begin
      fails++;
      $display("FAIL %s: sw_o actual=%b expected=%b at %0t", tag, sw_o, exp_v, $time);
    end
  endtask

  task automatic step(input logic c, input logic le, input logic ld, input logic [1:0] lm,
                      input logic [DLY_W-1:0] d, input logic t, input logic l, input string tag);
    string use_tag;
    logic  nsw;
    clr_i = c; latch_en_i = le; latch_dir_i = ld; loss_mode_i = lm;
    delay_i = d; tone_i = t; los_i = l;
    use_tag = (tag == "") ? auto_tag(c, l, lm) : tag;
    nsw = next_sw(c, le, ld, lm, d, t, l);
    @(posedge clk);
    m_sw = nsw;
    if (c) begin m_lat = le; m_dir = ld; end
    if (!l)             m_cnt = '0;
    else if (m_cnt < d) m_cnt = m_cnt + 1'b1;
    @(negedge clk);
    check(use_tag, m_sw);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run actual=hung expected=finished");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check("R1", 1'b0);
    rst_n = 1'b1;
    // R1: default after reset is unlatched
    step(0, 0, 0, 2'b10, 8'd3, 1, 0, "R1");
    step(0, 0, 0, 2'b10, 8'd3, 0, 0, "R1");
    // R3 latch to on
    step(1, 1, 1, 2'b10, 8'd3, 1, 0, "R5");
    step(0, 1, 1, 2'b10, 8'd3, 0, 0, "R3");
    step(0, 1, 1, 2'b10, 8'd3, 1, 0, "R3");
    step(0, 1, 1, 2'b10, 8'd3, 0, 0, "R3");
    // R6 latch pins change without clear: still latched on
    step(0, 0, 0, 2'b10, 8'd3, 0, 0, "R6");
    step(0, 0, 0, 2'b10, 8'd3, 0, 0, "R6");
    // R4 latch to off, idle level is on
    step(1, 1, 0, 2'b10, 8'd3, 1, 0, "R5");
    step(0, 1, 0, 2'b10, 8'd3, 1, 0, "R4");
    step(0, 1, 0, 2'b10, 8'd3, 0, 0, "R4");
    // R8 / R9 delayed policy with D=3, unlatched
    step(1, 0, 0, 2'b01, 8'd3, 1, 0, "R5");
    step(0, 0, 0, 2'b01, 8'd3, 1, 0, "R2");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 2'b01, 8'd3, 0, 1, "R8");
    step(0, 0, 0, 2'b01, 8'd3, 1, 0, "R9");
    for (int i = 0; i < 3; i++) step(0, 0, 0, 2'b01, 8'd3, 0, 1, "R9");
    step(0, 0, 0, 2'b01, 8'd3, 1, 1, "R8");
    // R8 zero delay acts at once
    step(0, 0, 0, 2'b01, 8'd0, 1, 0, "R2");
    step(0, 0, 0, 2'b01, 8'd0, 1, 1, "R8");
    // R10 hold ignores tone, then R11 policy change mid-loss
    step(0, 0, 0, 2'b10, 8'd3, 1, 0, "R2");
    step(0, 0, 0, 2'b10, 8'd3, 0, 1, "R10");
    step(0, 0, 0, 2'b11, 8'd3, 0, 1, "R10");
    step(0, 0, 0, 2'b00, 8'd3, 1, 1, "R11");
    step(0, 0, 0, 2'b00, 8'd3, 1, 0, "R2");
    // R7 latched-on then immediate fail-safe
    step(1, 1, 1, 2'b00, 8'd3, 0, 0, "R5");
    step(0, 1, 1, 2'b00, 8'd3, 1, 0, "R3");
    step(0, 1, 1, 2'b00, 8'd3, 1, 1, "R7");
    step(0, 1, 1, 2'b00, 8'd3, 0, 0, "R7");
    // random mix
    for (int i = 0; i < 4000; i++) begin
      step(($urandom % 16) == 0, $urandom % 2, $urandom % 2, 2'($urandom % 4),
           DLY_W'($urandom % 6), $urandom % 2, ($urandom % 3) == 0, "");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule